// File: doc/BRIEF.md
# Dual-Modulus Programmable Clock Divider

This block divides a fast input clock by any integer N between 12 and 259 and emits one retimed pulse per division period. A small prescaler counts either 4 or 5 input cycles per step. A 6-bit main counter counts prescaler steps to set the coarse length of each period. A 2-bit swallow counter chooses how many of those steps last 5 cycles. The output pulse is always 8 input cycles wide, whatever N is.

All logic runs on the input clock. The prescaler produces a one-cycle enable and does not drive a derived clock. The 8-bit division word is taken at the boundary of each output period, so a fractional-N controller can hand the block a new ratio every period. After reset is released, the divider starts at once with the programmed ratio. Several dividers released together therefore give aligned pulses.

Top module: `dmp_divider`

## Requirements
- R1: While `rst_n` is low, `pulse_out` is low.
- R2: The division word encodes N = 4·NA + NB. DA = `div_word[7:2]` and NB = `div_word[1:0]`. NA = 64 − DA when DA is nonzero, and NA = 64 when DA is zero. With a legal word, the distance between successive rising edges of `pulse_out` is N input cycles. Each rising edge follows a period boundary by one register.
- R3: Every N from 12 to 259 gives a period of exactly N cycles. This includes 256 to 259, which use DA = 0. Each pulse ends before the next period boundary.
- R4: Every pulse on `pulse_out` is high for exactly 8 consecutive input cycles.
- R5: Count the first clock edge that samples `rst_n` high as edge 0. The first rising edge of `pulse_out` occurs at edge N, where N is given by the word present at edge 0.
- R6: The word present at the clock edge that starts a period sets that period's length. Different values on consecutive periods each take effect.
- R7: Changes to `div_word` between period boundaries have no effect on the current period.
- R8: Each prescaler step is 4 or 5 cycles long. A step is 5 cycles long exactly when the modulus control chosen at its start asks for 5. The modulus control asks for 5 for the first NB steps of each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on a clock edge |
| div_word | input | 8 | Division word: DA in bits 7:2, NB in bits 1:0 |
| pulse_out | output | 1 | Divided output, 8-cycle pulse per period |

## Verification
The hardest case to reach from the ports is a ratio that changes on every period while other word changes arrive in between. A new word takes effect only at a boundary that is hidden inside the counters. The bench watches for each rising edge of `pulse_out` and writes the next word on the falling clock edge that follows it. This sets up a one-period pipeline, and the bench models it to predict each period length. It then sweeps all 248 legal ratios back to back. In another run it toggles the word in mid-period and restores it before the boundary, then checks that the period is unchanged.

// File: rtl/dmp_pkg.sv
`timescale 1ns/1ps
package dmp_pkg;
  typedef logic [2:0] js_t;
  // Johnson ring sequence: 001 -> 011 -> 111 -> 110 -> 100
  localparam js_t JS_LAST   = 3'b100;
  localparam js_t JS_ENTRY5 = 3'b001;
  localparam js_t JS_ENTRY4 = 3'b011;
endpackage

// File: rtl/dmp_prescaler.sv
`timescale 1ns/1ps
module dmp_prescaler
  import dmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mod5_nxt,
  output logic tick
);
  js_t js_q, js_d;

  assign tick = (js_q == JS_LAST);

  always_comb begin
    if (tick) js_d = mod5_nxt ? JS_ENTRY5 : JS_ENTRY4;
    else      js_d = {js_q[1:0], ~js_q[2]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) js_q <= JS_LAST;
    else        js_q <= js_d;
  end
endmodule

// File: rtl/dmp_count_a.sv
`timescale 1ns/1ps
module dmp_count_a #(
  parameter int unsigned A_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [A_BITS-1:0] da,
  output logic              term
);
  localparam int unsigned CW = A_BITS + 1;
  localparam logic [CW-1:0] FULL = CW'(2 ** A_BITS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] a_q, a_d, na;

  assign na   = (da == '0) ? FULL : (FULL - CW'(da));
  assign term = tick && (a_q == ONE);

  always_comb begin
    a_d = a_q;
    if (term)      a_d = na;
    else if (tick) a_d = a_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_q <= ONE;
    else        a_q <= a_d;
  end
endmodule

// File: rtl/dmp_swallow_b.sv
`timescale 1ns/1ps
module dmp_swallow_b #(
  parameter int unsigned B_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              term,
  input  logic [B_BITS-1:0] db,
  output logic              mod5_nxt
);
  logic [B_BITS-1:0] b_q, b_d;

  always_comb begin
    b_d = b_q;
    if (term)                   b_d = db;
    else if (tick && b_q != '0) b_d = b_q - B_BITS'(1);
  end

  assign mod5_nxt = (b_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_q <= '0;
    else        b_q <= b_d;
  end
endmodule

// File: rtl/dmp_pulse_gen.sv
`timescale 1ns/1ps
module dmp_pulse_gen #(
  parameter int unsigned PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic term,
  output logic pulse_out
);
  localparam int unsigned PW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;

  logic          armed_q, armed_d;
  logic          pls_q, pls_d;
  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    armed_d = armed_q;
    pls_d   = pls_q;
    pc_d    = pc_q;
    if (term) armed_d = 1'b1;
    if (term && armed_q) begin
      pls_d = 1'b1;
      pc_d  = PW'(PULSE_CYCLES - 1);
    end else if (pls_q) begin
      if (pc_q == '0) pls_d = 1'b0;
      else            pc_d  = pc_q - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pls_q   <= 1'b0;
      pc_q    <= '0;
    end else begin
      armed_q <= armed_d;
      pls_q   <= pls_d;
      pc_q    <= pc_d;
    end
  end

  assign pulse_out = pls_q;
endmodule

// File: rtl/dmp_divider.sv
`timescale 1ns/1ps
module dmp_divider #(
  parameter int unsigned A_BITS       = 6,
  parameter int unsigned B_BITS       = 2,
  parameter int unsigned PULSE_CYCLES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [A_BITS+B_BITS-1:0] div_word,
  output logic                     pulse_out
);
  logic ps_tick, a_term, mod5_nxt;

  dmp_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .mod5_nxt(mod5_nxt), .tick(ps_tick)
  );

  dmp_count_a #(.A_BITS(A_BITS)) u_cnt_a (
    .clk(clk), .rst_n(rst_n), .tick(ps_tick),
    .da(div_word[A_BITS+B_BITS-1:B_BITS]), .term(a_term)
  );

  dmp_swallow_b #(.B_BITS(B_BITS)) u_cnt_b (
    .clk(clk), .rst_n(rst_n), .tick(ps_tick), .term(a_term),
    .db(div_word[B_BITS-1:0]), .mod5_nxt(mod5_nxt)
  );

  dmp_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .term(a_term), .pulse_out(pulse_out)
  );
endmodule

// File: rtl/dmp_divider_chk.sv
`timescale 1ns/1ps
module dmp_divider_chk #(
  parameter int unsigned PULSE_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic term,
  input logic mod5,
  input logic pulse_out
);
  localparam int unsigned HW = $clog2(PULSE_CYCLES + 2) + 1;

  logic [3:0]    gap_q;
  logic          seen_q, lmod_q;
  logic [HW-1:0] hc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      lmod_q <= 1'b0;
      hc_q   <= '0;
    end else begin
      if (tick) begin
        gap_q  <= 4'd1;
        seen_q <= 1'b1;
        lmod_q <= mod5;
      end else if (gap_q != 4'hF) begin
        gap_q <= gap_q + 4'd1;
      end
      if (pulse_out) hc_q <= hc_q + HW'(1);
      else           hc_q <= '0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!pulse_out);
  end

  assert_step_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_q) |-> (gap_q == (lmod_q ? 4'd5 : 4'd4)));

  assert_rise_after_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> $past(term));

  assert_pulse_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> !pulse_out);

  assert_pulse_not_long_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> (hc_q < HW'(PULSE_CYCLES)));

  assert_pulse_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_out) |-> (hc_q == HW'(PULSE_CYCLES)));
endmodule

bind dmp_divider dmp_divider_chk #(.PULSE_CYCLES(PULSE_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(ps_tick), .term(a_term),
  .mod5(mod5_nxt), .pulse_out(pulse_out)
);

// File: tb/dmp_divider_tb.sv
`timescale 1ns/1ps
module dmp_divider_tb_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] div_word;
  logic       pulse_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cur_n    = 12;
  int latched  = 12;

  dmp_divider dut_i (
    .clk(clk), .rst_n(rst_n), .div_word(div_word), .pulse_out(pulse_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] enc(input int n);
    int na;
    int da;
    na = n / 4;
    da = (na == 64) ? 0 : 64 - na;
    return {da[5:0], 2'(n % 4)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait for the next rising edge of pulse_out, sampling at falling clock edges.
  task automatic wait_rise(output int gap, output int hi);
    logic lp;
    gap = 0;
    hi  = 0;
    lp  = pulse_out;
    forever begin
      @(negedge clk);
      gap++;
      if (pulse_out && !lp) break;
      if (pulse_out) hi++;
      lp = pulse_out;
      if (gap > 2000) break;
    end
  endtask

  task automatic set_n(input int n);
    cur_n    = n;
    div_word = enc(n);
  endtask

  // One period step: check the period that just ended, then program the next ratio.
  task automatic step(input int n_next, input string req, input bit chk_w);
    int g;
    int h;
    wait_rise(g, h);
    chk(g == latched, req, g, latched);
    if (chk_w) chk(h + 1 == 8, "R4 width", h + 1, 8);
    latched = cur_n;
    set_n(n_next);
  endtask

  task automatic t_reset_idle;
    rst_n = 1'b0;
    set_n(12);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pulse_out) break;
    end
    chk(pulse_out == 1'b0, "R1 reset idle", int'(pulse_out), 0);
  endtask

  task automatic t_first_pulse(input int n);
    int k;
    rst_n = 1'b0;
    set_n(n);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    while (!pulse_out && k < 400) begin
      @(negedge clk);
      k++;
    end
    chk(k == n + 1, "R5 first pulse", k - 1, n);
    latched = n;
  endtask

  task automatic t_sweep;
    set_n(12);
    step(12, "R6 sweep prime", 1'b0);
    for (int n = 13; n <= 259; n++) step(n, "R3 R8 period sweep", 1'b1);
    step(259, "R3 R8 period sweep", 1'b1);
    step(259, "R3 R8 period sweep", 1'b1);
  endtask

  task automatic t_consecutive;
    int seq [8] = '{12, 259, 13, 200, 64, 15, 256, 99};
    foreach (seq[i]) step(seq[i], "R6 consecutive", 1'b0);
    step(99, "R6 consecutive", 1'b1);
    step(99, "R2 period", 1'b1);
  endtask

  task automatic t_midchange;
    int g;
    int h;
    set_n(77);
    step(77, "R7 settle", 1'b0);
    step(77, "R7 settle", 1'b0);
    for (int r = 0; r < 3; r++) begin
      fork
        wait_rise(g, h);
        begin
          repeat (5) @(negedge clk);
          div_word = enc(13);
          repeat (20) @(negedge clk);
          div_word = enc(250);
          repeat (20) @(negedge clk);
          div_word = enc(77);
        end
      join
      chk(g == 77, "R7 mid-period change", g, 77);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n    = 1'b1;
    div_word = enc(12);
    #2 rst_n = 1'b0;
    t_reset_idle();
    t_first_pulse(12);
    t_first_pulse(37);
    t_first_pulse(259);
    t_first_pulse(256);
    t_first_pulse(30);
    t_sweep();
    t_consecutive();
    t_midchange();
    t_reset_idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule